// File: doc/BRIEF.md
# Data Address Translation Buffer

This block translates the virtual address of a load or store into a physical address, or reports why it cannot. It holds a small fully associative set of page mappings, each tagged with a virtual page number and an address space number. Each mapping carries per-mode read and write enables and two fault-on-access bits, one for reads and one for writes. A request may also bypass the table in two ways. A physical-mode request passes the address through unchanged. A kernel access to the superpage region maps the address directly.

The block evaluates a request combinationally. It registers the result on the request strobe, so the response appears on the next cycle. A single round-robin pointer serves two purposes. It selects the entry that a new insert overwrites, and it selects the entry that is presented on a readout port. The readout can be sampled without moving the pointer, and the pointer steps only when the caller asks for it. A flush clears every mapping at once.

Top module: `dtb_xlate`

## Requirements
- R1: A request with `req_phys` set returns `rsp_pa = req_va[39:0]`, fault code 0 and status 0, whatever the other inputs are.
- R2: Otherwise, if `req_va[63:42]` is neither all zeros nor all ones, the response is fault code 2 (protection/translation fault). The status has ACV (bit 1) set, and WR (bit 0) set when the request is a store.
- R3: A request whose address is valid, with `req_sp_en[1]` set and `req_va[42:41] = 2'b10`, in kernel mode (`req_mode = 0`), returns `rsp_pa = req_va[39:0]`, fault 0 and status 0, and no table lookup is made. With `req_sp_en[1]` clear, the same address goes to the table instead.
- R4: A superpage request made in a mode other than kernel returns fault code 1 (access violation). The status has ACV set, and WR set when the request is a store.
- R5: A table miss returns fault code 3, or fault code 4 when `req_walk` is set. The status has MISS (bit 4) set, and WR set for stores.
- R6: An entry hits only when both its page number (`req_va[42:13]`) and its address space number match the request. A hit with no permission fault returns `rsp_pa = {pfn, req_va[12:0]}`, fault 0 and status 0.
- R7: On a store hit, if the entry's write enable for the current mode is clear, the response is fault 2 with status WR|ACV, plus FONW (bit 3) when that entry's fault-on-write bit is set. If the store is allowed but fault-on-write is set, the response is fault 2 with status WR|FONW.
- R8: On a load hit, if the entry's read enable for the current mode is clear, the response is fault 1 with status ACV, plus FONR (bit 2) when fault-on-read is set. If the load is allowed but fault-on-read is set, the response is fault 2 with status FONR. Enable bit n belongs to mode n.
- R9: `rd_data` shows the entry at the pointer, with its frame number in bits 58:32, its read enables in bits 11:8, and zeros elsewhere. The pointer resets to 0. It steps by one only on `rd_adv` or on an accepted insert, and wraps after entry 15.
- R10: An insert writes the mapping into the entry at the pointer, then advances the pointer.
- R11: A flush invalidates every entry. If an insert arrives in the same cycle as a flush, the insert is ignored and does not move the pointer.
- R12: `rsp_valid` is high exactly one cycle after `req_valid`. The response outputs hold their values between requests, and all of them are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translate request strobe |
| req_va | input | 64 | Virtual address |
| req_phys | input | 1 | Physical-mode request: pass the address through |
| req_walk | input | 1 | Request comes from a page-table walk |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Current mode, 0 = kernel |
| req_asn | input | 8 | Address space number |
| req_sp_en | input | 2 | Superpage enables; bit 1 governs this region |
| ins_valid | input | 1 | Insert strobe |
| ins_vpn | input | 30 | Page number of the new mapping |
| ins_asn | input | 8 | Address space of the new mapping |
| ins_pfn | input | 27 | Frame number of the new mapping |
| ins_rd_en | input | 4 | Per-mode read enables |
| ins_wr_en | input | 4 | Per-mode write enables |
| ins_fonr | input | 1 | Fault-on-read bit |
| ins_fonw | input | 1 | Fault-on-write bit |
| flush | input | 1 | Invalidate all entries |
| rd_adv | input | 1 | Step the pointer after this readout |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 40 | Physical address |
| rsp_fault | output | 3 | Fault code: 0 none, 1 ACV, 2 fault, 3 miss, 4 walk miss |
| rsp_stat | output | 5 | Status: WR, ACV, FONR, FONW, MISS in bits 0 to 4 |
| rd_data | output | 64 | Entry at the pointer |

## Verification
A wrong pointer shows up on `rd_data` in the same cycle, and it also shows up on the next insert, which lands in the wrong slot. A corrupted valid bit or tag turns an expected hit into a miss, or the reverse, on the very next request. That error shows on `rsp_fault` one cycle after the strobe. A permission or fault-on-access bit stored in the wrong place shows only when a request in the affected mode and direction touches that entry, so the tests cover every mode and direction combination against deliberately mixed entries.

// File: rtl/dtb_pkg.sv
// Shared codes for the data translation buffer.
// Assumes a 2-bit mode where value n selects enable bit n.
package dtb_pkg;
    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_ACV       = 3'd1,
        FLT_PROT      = 3'd2,
        FLT_MISS      = 3'd3,
        FLT_WALK_MISS = 3'd4
    } dtb_fault_e;

    localparam int STAT_W  = 5;
    localparam int ST_WR   = 0;
    localparam int ST_ACV  = 1;
    localparam int ST_FONR = 2;
    localparam int ST_FONW = 3;
    localparam int ST_MISS = 4;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/dtb_rr_ptr.sv
// Round-robin entry pointer. Steps by one on 'step' and wraps after
// the last entry. Assumes ENTRIES >= 2.
module dtb_rr_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    // Advance or hold the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/dtb_entry_array.sv
// Storage and associative match for the mappings. The lowest matching
// index wins if several entries match. Flush clears the valid bits, and
// it takes precedence over a write in the same cycle.
module dtb_entry_array #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 8,
    parameter int PFN_W   = 27,
    parameter int NMODE   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [ASN_W-1:0]   wr_asn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [NMODE-1:0]   wr_rd_en,
    input  logic [NMODE-1:0]   wr_wr_en,
    input  logic               wr_fonr,
    input  logic               wr_fonw,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASN_W-1:0]   lk_asn,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [NMODE-1:0]   lk_rd_en,
    output logic [NMODE-1:0]   lk_wr_en,
    output logic               lk_fonr,
    output logic               lk_fonw,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [PFN_W-1:0]   rd_pfn,
    output logic [NMODE-1:0]   rd_rd_en,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [VPN_W-1:0] e_vpn  [ENTRIES];
    logic [ASN_W-1:0] e_asn  [ENTRIES];
    logic [PFN_W-1:0] e_pfn  [ENTRIES];
    logic [NMODE-1:0] e_rd   [ENTRIES];
    logic [NMODE-1:0] e_wr   [ENTRIES];
    logic             e_fonr [ENTRIES];
    logic             e_fonw [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Hold one mapping; clear it on reset, invalidate it on flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                e_vpn[g]     <= '0;
                e_asn[g]     <= '0;
                e_pfn[g]     <= '0;
                e_rd[g]      <= '0;
                e_wr[g]      <= '0;
                e_fonr[g]    <= 1'b0;
                e_fonw[g]    <= 1'b0;
            end else if (flush) begin
                valid_vec[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_vec[g] <= 1'b1;
                e_vpn[g]     <= wr_vpn;
                e_asn[g]     <= wr_asn;
                e_pfn[g]     <= wr_pfn;
                e_rd[g]      <= wr_rd_en;
                e_wr[g]      <= wr_wr_en;
                e_fonr[g]    <= wr_fonr;
                e_fonw[g]    <= wr_fonw;
            end
        end
        // Tag compare for this entry.
        assign match[g] = valid_vec[g] && e_vpn[g] == lk_vpn && e_asn[g] == lk_asn;
    end

    // Select the lowest matching entry.
    always_comb begin
        lk_hit   = |match;
        lk_pfn   = '0;
        lk_rd_en = '0;
        lk_wr_en = '0;
        lk_fonr  = 1'b0;
        lk_fonw  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_pfn   = e_pfn[i];
                lk_rd_en = e_rd[i];
                lk_wr_en = e_wr[i];
                lk_fonr  = e_fonr[i];
                lk_fonw  = e_fonw[i];
            end
        end
    end

    // Readout of the entry at the pointer.
    assign rd_pfn   = e_pfn[rd_idx];
    assign rd_rd_en = e_rd[rd_idx];
endmodule

// File: rtl/dtb_perm_check.sv
// Permission and fault-on-access evaluation for a hit. Purely
// combinational; the mode selects one bit of each enable field.
module dtb_perm_check
    import dtb_pkg::*;
#(
    parameter int NMODE = 4
) (
    input  logic                    is_store,
    input  logic [$clog2(NMODE)-1:0] mode,
    input  logic [NMODE-1:0]        rd_en,
    input  logic [NMODE-1:0]        wr_en,
    input  logic                    fonr,
    input  logic                    fonw,
    output dtb_fault_e              fault,
    output logic [STAT_W-1:0]       stat
);
    // Order: enable check first, then fault-on-access.
    always_comb begin
        fault = FLT_NONE;
        stat  = '0;
        if (is_store) begin
            if (!wr_en[mode]) begin
                fault         = FLT_PROT;
                stat[ST_WR]   = 1'b1;
                stat[ST_ACV]  = 1'b1;
                stat[ST_FONW] = fonw;
            end else if (fonw) begin
                fault         = FLT_PROT;
                stat[ST_WR]   = 1'b1;
                stat[ST_FONW] = 1'b1;
            end
        end else begin
            if (!rd_en[mode]) begin
                fault         = FLT_ACV;
                stat[ST_ACV]  = 1'b1;
                stat[ST_FONR] = fonr;
            end else if (fonr) begin
                fault         = FLT_PROT;
                stat[ST_FONR] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtb_xlate.sv
// Data translation buffer top. Chooses physical pass-through, address
// validity fault, superpage bypass or table lookup, and registers the
// result on req_valid. Assumes a sign-extended virtual space of VA_IMPL
// bits and a superpage region selected by the top two implemented bits.
module dtb_xlate
    import dtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43,
    parameter int PA_W    = 40,
    parameter int PG_W    = 13,
    parameter int ASN_W   = 8,
    parameter int NMODE   = 4,
    parameter int RD_PFN_LSB = 32,
    parameter int RD_EN_LSB  = 8,
    localparam int VPN_W  = VA_IMPL - PG_W,
    localparam int PFN_W  = PA_W - PG_W,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int MODE_W = $clog2(NMODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_phys,
    input  logic              req_walk,
    input  logic              req_store,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [ASN_W-1:0]  req_asn,
    input  logic [1:0]        req_sp_en,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic [NMODE-1:0]  ins_rd_en,
    input  logic [NMODE-1:0]  ins_wr_en,
    input  logic              ins_fonr,
    input  logic              ins_fonw,
    input  logic              flush,
    input  logic              rd_adv,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [2:0]        rsp_fault,
    output logic [STAT_W-1:0] rsp_stat,
    output logic [63:0]       rd_data
);
    logic [IDX_W-1:0]   rr_ptr;
    logic [ENTRIES-1:0] ent_valid;
    logic               ins_take;
    logic               lk_hit, lk_fonr, lk_fonw;
    logic [PFN_W-1:0]   lk_pfn, rd_pfn;
    logic [NMODE-1:0]   lk_rd_en, lk_wr_en, rd_rd_en;
    dtb_fault_e         pc_fault;
    logic [STAT_W-1:0]  pc_stat;
    logic               va_ok, sp_hit;
    dtb_fault_e         nx_fault;
    logic [STAT_W-1:0]  nx_stat;
    logic [PA_W-1:0]    nx_pa;

    assign ins_take = ins_valid && !flush;

    dtb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(rd_adv || ins_take), .ptr(rr_ptr)
    );

    dtb_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W), .NMODE(NMODE)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(ins_take), .wr_idx(rr_ptr), .wr_vpn(ins_vpn), .wr_asn(ins_asn),
        .wr_pfn(ins_pfn), .wr_rd_en(ins_rd_en), .wr_wr_en(ins_wr_en),
        .wr_fonr(ins_fonr), .wr_fonw(ins_fonw),
        .lk_vpn(req_va[VA_IMPL-1:PG_W]), .lk_asn(req_asn),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_fonr(lk_fonr), .lk_fonw(lk_fonw),
        .rd_idx(rr_ptr), .rd_pfn(rd_pfn), .rd_rd_en(rd_rd_en), .valid_vec(ent_valid)
    );

    dtb_perm_check #(.NMODE(NMODE)) u_perm (
        .is_store(req_store), .mode(req_mode), .rd_en(lk_rd_en), .wr_en(lk_wr_en),
        .fonr(lk_fonr), .fonw(lk_fonw), .fault(pc_fault), .stat(pc_stat)
    );

    // Upper bits must all repeat the top implemented bit.
    assign va_ok  = (&req_va[VA_W-1:VA_IMPL-1]) || !(|req_va[VA_W-1:VA_IMPL-1]);
    assign sp_hit = req_sp_en[1] && req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10;

    // Pick the translation path in priority order.
    always_comb begin
        nx_fault = FLT_NONE;
        nx_stat  = '0;
        nx_pa    = req_va[PA_W-1:0];
        if (req_phys) begin
            nx_pa = req_va[PA_W-1:0];
        end else if (!va_ok) begin
            nx_fault        = FLT_PROT;
            nx_stat[ST_ACV] = 1'b1;
            nx_stat[ST_WR]  = req_store;
        end else if (sp_hit) begin
            if (req_mode != MODE_KERNEL) begin
                nx_fault        = FLT_ACV;
                nx_stat[ST_ACV] = 1'b1;
                nx_stat[ST_WR]  = req_store;
            end
        end else if (!lk_hit) begin
            nx_fault         = req_walk ? FLT_WALK_MISS : FLT_MISS;
            nx_stat[ST_MISS] = 1'b1;
            nx_stat[ST_WR]   = req_store;
        end else begin
            nx_pa    = {lk_pfn, req_va[PG_W-1:0]};
            nx_fault = pc_fault;
            nx_stat  = pc_stat;
        end
    end

    // Register the response on the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= '0;
            rsp_stat  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa    <= nx_pa;
                rsp_fault <= nx_fault;
                rsp_stat  <= nx_stat;
            end
        end
    end

    // Pack the pointed-at entry for readout.
    always_comb begin
        rd_data = '0;
        rd_data[RD_PFN_LSB +: PFN_W] = rd_pfn;
        rd_data[RD_EN_LSB +: NMODE]  = rd_rd_en;
    end
endmodule

// File: rtl/dtb_xlate_chk.sv
// Protocol checker for dtb_xlate, attached by bind below.
module dtb_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_va,
    input logic        req_phys,
    input logic [1:0]  req_mode,
    input logic [1:0]  req_sp_en,
    input logic        ins_valid,
    input logic        flush,
    input logic        rd_adv,
    input logic        rsp_valid,
    input logic [39:0] rsp_pa,
    input logic [2:0]  rsp_fault,
    input logic [4:0]  rsp_stat,
    input logic [3:0]  rr_ptr,
    input logic [15:0] ent_valid
);
    AST_PHYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_phys |=> rsp_pa == $past(req_va[39:0]) && rsp_fault == 3'd0 && rsp_stat == 5'd0); // R1
    AST_SUPER_USER_ACV: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_phys && (&req_va[63:42]) && req_va[41] == 1'b0 && req_sp_en[1] && req_mode != 2'd0
        |=> rsp_fault == 3'd1 && rsp_stat[1]); // R4
    AST_CLEAN_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 3'd0 |-> rsp_stat == 5'd0); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_adv && !(ins_valid && !flush) |=> $stable(rr_ptr)); // R9
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ent_valid == 16'd0); // R11
    AST_RSP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid)); // R12
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_stat)); // R12
endmodule

bind dtb_xlate dtb_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_phys(req_phys), .req_mode(req_mode), .req_sp_en(req_sp_en),
    .ins_valid(ins_valid), .flush(flush), .rd_adv(rd_adv),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_stat(rsp_stat),
    .rr_ptr(rr_ptr), .ent_valid(ent_valid)
);

// File: tb/dtb_xlate_tb.sv
// Directed bench for dtb_xlate: one task per scenario.
module dtb_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_phys = 0, req_walk = 0, req_store = 0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_mode = '0, req_sp_en = '0;
    logic [7:0]  req_asn = '0;
    logic        ins_valid = 0, ins_fonr = 0, ins_fonw = 0, flush = 0, rd_adv = 0;
    logic [29:0] ins_vpn = '0;
    logic [7:0]  ins_asn = '0;
    logic [26:0] ins_pfn = '0;
    logic [3:0]  ins_rd_en = '0, ins_wr_en = '0;
    logic        rsp_valid;
    logic [39:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic [4:0]  rsp_stat;
    logic [63:0] rd_data;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dtb_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_phys(req_phys), .req_walk(req_walk), .req_store(req_store),
        .req_mode(req_mode), .req_asn(req_asn), .req_sp_en(req_sp_en),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_pfn(ins_pfn),
        .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en), .ins_fonr(ins_fonr), .ins_fonw(ins_fonw),
        .flush(flush), .rd_adv(rd_adv), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_stat(rsp_stat), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] va_of(input logic [29:0] vpn, input logic [12:0] off);
        return {{21{vpn[29]}}, vpn, off};
    endfunction

    function automatic logic [63:0] rd_exp(input logic [26:0] pfn, input logic [3:0] rd);
        logic [63:0] v = '0;
        v[58:32] = pfn;
        v[11:8]  = rd;
        return v;
    endfunction

    // Issue one request; the response is sampled one edge later.
    task automatic do_req(input logic [63:0] va, input logic phys, input logic walk,
                          input logic store, input logic [1:0] mode, input logic [7:0] asn,
                          input logic [1:0] sp);
        @(negedge clk);
        req_valid = 1; req_va = va; req_phys = phys; req_walk = walk;
        req_store = store; req_mode = mode; req_asn = asn; req_sp_en = sp;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_ins(input logic [29:0] vpn, input logic [7:0] asn, input logic [26:0] pfn,
                          input logic [3:0] rd, input logic [3:0] wr, input logic fr, input logic fw);
        @(negedge clk);
        ins_valid = 1; ins_vpn = vpn; ins_asn = asn; ins_pfn = pfn;
        ins_rd_en = rd; ins_wr_en = wr; ins_fonr = fr; ins_fonw = fw;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic t_reset();
        chk("R12 reset rsp_valid", 64'(rsp_valid), 0);
        chk("R12 reset rsp_pa", 64'(rsp_pa), 0);
        chk("R12 reset rsp_fault", 64'(rsp_fault), 0);
        chk("R9 reset readout", rd_data, 0);
    endtask

    task automatic t_phys();
        do_req(64'hFFFF_0000_1234_5678, 1, 1, 1, 2'd3, 8'd1, 2'b10);
        chk("R1 phys valid", 64'(rsp_valid), 1);
        chk("R1 phys pa", 64'(rsp_pa), 64'h00_1234_5678);
        chk("R1 phys fault", 64'(rsp_fault), 0);
        chk("R1 phys stat", 64'(rsp_stat), 0);
    endtask

    task automatic t_badva();
        do_req(64'h0000_1000_0000_0000, 0, 0, 1, 2'd0, 8'd0, 2'b00);
        chk("R2 bad va store fault", 64'(rsp_fault), 2);
        chk("R2 bad va store stat", 64'(rsp_stat), 5'b00011);
        do_req(64'hFF00_0000_0000_0000, 0, 0, 0, 2'd0, 8'd0, 2'b10);
        chk("R2 bad va load stat", 64'(rsp_stat), 5'b00010);
    endtask

    task automatic t_super();
        do_req(64'hFFFF_FC12_3456_7890, 0, 0, 0, 2'd0, 8'd0, 2'b10);
        chk("R3 superpage pa", 64'(rsp_pa), 64'h12_3456_7890);
        chk("R3 superpage fault", 64'(rsp_fault), 0);
        do_req(64'hFFFF_FC12_3456_7890, 0, 0, 0, 2'd0, 8'd0, 2'b01);
        chk("R3 superpage disabled goes to table", 64'(rsp_fault), 3);
        do_req(64'hFFFF_FC12_3456_7890, 0, 0, 0, 2'd3, 8'd0, 2'b10);
        chk("R4 user superpage load fault", 64'(rsp_fault), 1);
        chk("R4 user superpage load stat", 64'(rsp_stat), 5'b00010);
        do_req(64'hFFFF_FC12_3456_7890, 0, 0, 1, 2'd1, 8'd0, 2'b10);
        chk("R4 exec superpage store stat", 64'(rsp_stat), 5'b00011);
    endtask

    task automatic t_miss();
        do_req(va_of(30'h1234, 13'h0ABC), 0, 0, 0, 2'd0, 8'd5, 2'b00);
        chk("R5 miss load fault", 64'(rsp_fault), 3);
        chk("R5 miss load stat", 64'(rsp_stat), 5'b10000);
        do_req(va_of(30'h1234, 13'h0ABC), 0, 1, 1, 2'd0, 8'd5, 2'b00);
        chk("R5 walk miss store fault", 64'(rsp_fault), 4);
        chk("R5 walk miss store stat", 64'(rsp_stat), 5'b10001);
    endtask

    task automatic t_insert_hit();
        do_ins(30'h1234, 8'd5, 27'h55AA11, 4'b1111, 4'b0001, 0, 0);
        chk("R10 pointer moved after insert", rd_data, 0);
        do_req(va_of(30'h1234, 13'h0ABC), 0, 0, 0, 2'd2, 8'd5, 2'b00);
        chk("R6 hit pa", 64'(rsp_pa), 64'({27'h55AA11, 13'h0ABC}));
        chk("R6 hit fault", 64'(rsp_fault), 0);
        chk("R6 hit stat", 64'(rsp_stat), 0);
        do_req(va_of(30'h1234, 13'h0ABC), 0, 0, 0, 2'd0, 8'd6, 2'b00);
        chk("R6 asn mismatch misses", 64'(rsp_fault), 3);
        do_req(va_of(30'h1235, 13'h0ABC), 0, 0, 0, 2'd0, 8'd5, 2'b00);
        chk("R6 vpn mismatch misses", 64'(rsp_fault), 3);
    endtask

    task automatic t_perms();
        do_ins(30'h2000, 8'd5, 27'h000111, 4'b1111, 4'b1111, 1, 1);
        do_ins(30'h3FFF_FFFF, 8'd5, 27'h7FFFFFF, 4'b0000, 4'b0000, 1, 1);
        do_req(va_of(30'h1234, 13'h0), 0, 0, 1, 2'd3, 8'd5, 2'b00);
        chk("R7 store no enable fault", 64'(rsp_fault), 2);
        chk("R7 store no enable stat", 64'(rsp_stat), 5'b00011);
        do_req(va_of(30'h1234, 13'h10), 0, 0, 1, 2'd0, 8'd5, 2'b00);
        chk("R7 store kernel allowed", 64'(rsp_fault), 0);
        do_req(va_of(30'h2000, 13'h0), 0, 0, 1, 2'd0, 8'd5, 2'b00);
        chk("R7 store fonw fault", 64'(rsp_fault), 2);
        chk("R7 store fonw stat", 64'(rsp_stat), 5'b01001);
        do_req(va_of(30'h3FFF_FFFF, 13'h0), 0, 0, 1, 2'd1, 8'd5, 2'b00);
        chk("R7 store denied with fonw stat", 64'(rsp_stat), 5'b01011);
        do_req(va_of(30'h3FFF_FFFF, 13'h0), 0, 0, 0, 2'd2, 8'd5, 2'b00);
        chk("R8 load denied fault", 64'(rsp_fault), 1);
        chk("R8 load denied stat", 64'(rsp_stat), 5'b00110);
        do_req(va_of(30'h2000, 13'h0), 0, 0, 0, 2'd3, 8'd5, 2'b00);
        chk("R8 load fonr fault", 64'(rsp_fault), 2);
        chk("R8 load fonr stat", 64'(rsp_stat), 5'b00100);
    endtask

    task automatic t_readout();
        chk("R9 readout empty slot 3", rd_data, 0);
        @(negedge clk);
        chk("R9 readout holds without advance", rd_data, 0);
        for (int k = 0; k < 13; k++) begin
            rd_adv = 1;
            @(negedge clk);
        end
        rd_adv = 0;
        chk("R9 readout wraps to entry 0", rd_data, rd_exp(27'h55AA11, 4'b1111));
        rd_adv = 1;
        @(negedge clk);
        rd_adv = 0;
        chk("R10 entry 1 at slot 1", rd_data, rd_exp(27'h000111, 4'b1111));
        rd_adv = 1;
        @(negedge clk);
        rd_adv = 0;
        chk("R10 entry 2 at slot 2", rd_data, rd_exp(27'h7FFFFFF, 4'b0000));
        for (int k = 0; k < 14; k++) begin
            rd_adv = 1;
            @(negedge clk);
        end
        rd_adv = 0;
        chk("R9 back at slot 0", rd_data, rd_exp(27'h55AA11, 4'b1111));
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush = 1; ins_valid = 1; ins_vpn = 30'h4444; ins_asn = 8'd5;
        ins_pfn = 27'h0ABCDE; ins_rd_en = 4'b0101; ins_wr_en = 4'b0101;
        @(negedge clk);
        flush = 0; ins_valid = 0;
        chk("R11 insert ignored during flush", rd_data, rd_exp(27'h55AA11, 4'b1111));
        do_req(va_of(30'h1234, 13'h0ABC), 0, 0, 0, 2'd0, 8'd5, 2'b00);
        chk("R11 flushed entry misses", 64'(rsp_fault), 3);
        do_req(va_of(30'h4444, 13'h0), 0, 0, 0, 2'd0, 8'd5, 2'b00);
        chk("R11 flush-cycle insert absent", 64'(rsp_fault), 3);
    endtask

    task automatic t_hold();
        do_req(64'h0000_0000_0000_7777, 1, 0, 0, 2'd0, 8'd0, 2'b00);
        @(negedge clk);
        chk("R12 rsp_valid one cycle only", 64'(rsp_valid), 0);
        chk("R12 pa holds", 64'(rsp_pa), 64'h7777);
        req_va = 64'h1111;
        @(negedge clk);
        chk("R12 pa holds without strobe", 64'(rsp_pa), 64'h7777);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_phys();
        t_badva();
        t_super();
        t_miss();
        t_insert_hit();
        t_perms();
        t_readout();
        t_flush();
        t_hold();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule